// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block sets the integer division value that a fractional-N loop divider uses in each reference period. Software writes a 9-bit integer field and a signed fractional dividend through a small register write port. The divider applies a fixed bias of 32 on top of the integer field. The dividend resolution is selectable: 10 bits, giving steps of 1/1024, or 18 bits, giving steps of 1/262144. A third-order delta-sigma modulator of the cascaded-accumulator (MASH 1-1-1) kind dithers the ratio from tick to tick. Over time the mean of the ratio equals the programmed fractional value.

The integer field and the low dividend byte are held in staging registers. A new ratio takes effect only when the dividend upper part is written, so the divider never sees a half-updated value. In integer mode the modulator is held cleared and bypassed, and a divider write takes effect at once. A signed modulation offset can be written at any time. It is added to the committed dividend ahead of the modulator, with saturation at the dividend range, so that direct frequency modulation can ride on the carrier. The output register advances only on the reference-rate tick.

Top module: `fracn_ratio_seq`

## Requirements
- R1: After reset the block is in integer mode with 10-bit resolution, every field and the offset are zero, and ratio_o reads 32.
- R2: In integer mode a write of the integer field (select 1, data bits 8:0) commits at once; the next tick sets ratio_o to field+32, which covers 32 to 543.
- R3: ratio_o changes only on a clock edge where tick_i is high, and then takes the value computed from the state held before that edge.
- R4: In 18-bit fractional mode the dividend is the signed 18-bit value {upper 10 bits, low byte}, and the mean of ratio_o over many ticks equals field+32+dividend/262144.
- R5: In 10-bit fractional mode the dividend is the signed 10-bit value in the upper register, and the mean of ratio_o equals field+32+dividend/1024.
- R6: In fractional mode, writes of the integer field and of the low byte are staged only; both commit together when the upper dividend register (select 3) is written.
- R7: In integer mode, a write of the upper dividend register changes neither the committed field nor the committed dividend.
- R8: In fractional mode the modulator adds between -3 and +4 to each tick's ratio, so the ratio stays within committed field+32-4 to field+32+4. The extra -1 applies to a negative dividend.
- R9: The 16-bit signed offset (select 4) is added to the committed dividend, and the sum saturates at -131072..131071 in 18-bit mode and at -512..511 in 10-bit mode.
- R10: Write select codes: 0 sets the mode (data bit 0 selects fractional, data bit 1 selects 18-bit resolution), 1 writes the integer field, 2 the low dividend byte (bits 7:0), 3 the upper dividend (bits 9:0), and 4 the offset (bits 15:0). Other codes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | 16 | Register write data |
| tick_i | input | 1 | Reference-rate tick; one new ratio per tick |
| ratio_o | output | 10 | Instantaneous divide ratio |

## Verification
Integer mode is tried with field values at both ends and in the middle, with ticks held off and then pulsed. This separates the commit timing from the output update timing. Fractional mode is tried with zero, positive and negative dividends at both resolutions, and the long-run mean is compared with the programmed ratio. A wrong weight, a wrong sign or a lost carry shows up in that mean, while a per-cycle reference model catches dither sequence faults. Offset patterns that stay inside the dividend range and patterns that overflow it, in both modes, separate plain addition from saturation. Staged-only and ignored writes are checked by observing that the mean is unchanged.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  localparam int INT_W      = 9;
  localparam int WIDE_W     = 18;
  localparam int NARROW_W   = 10;
  localparam int LO_W       = 8;
  localparam int MOD_W      = 16;
  localparam int DATA_W     = 16;
  localparam int RATIO_W    = 10;
  localparam int RATIO_BIAS = 32;
  localparam int SEL_W      = 3;
  localparam int DITHER_W   = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG = 3'd0,
    SEL_INT = 3'd1,
    SEL_LO  = 3'd2,
    SEL_HI  = 3'd3,
    SEL_MOD = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/fnr_regs.sv
module fnr_regs
  import fnr_pkg::*;
#(
  parameter int P_INT_W    = INT_W,
  parameter int P_WIDE_W   = WIDE_W,
  parameter int P_NARROW_W = NARROW_W,
  parameter int P_LO_W     = LO_W,
  parameter int P_MOD_W    = MOD_W,
  parameter int P_DATA_W   = DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SEL_W-1:0]           wr_sel_i,
  input  logic [P_DATA_W-1:0]        wr_data_i,
  output logic                       frac_en_o,
  output logic                       wide_o,
  output logic [P_INT_W-1:0]         act_int_o,
  output logic signed [P_WIDE_W-1:0] act_div_o,
  output logic signed [P_MOD_W-1:0]  mod_o
);
  localparam int HI_W = P_WIDE_W - P_LO_W;
  localparam int EXT_W = P_WIDE_W - P_NARROW_W;

  logic [P_INT_W-1:0] st_int_q;
  logic [P_LO_W-1:0]  st_lo_q;
  logic signed [P_WIDE_W-1:0] hi_div;

  // upper write: full 18-bit join or sign-extended 10-bit value
  always_comb begin
    if (wide_o) hi_div = {wr_data_i[HI_W-1:0], st_lo_q};
    else        hi_div = {{EXT_W{wr_data_i[P_NARROW_W-1]}}, wr_data_i[P_NARROW_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_en_o <= 1'b0;
      wide_o    <= 1'b0;
      st_int_q  <= '0;
      st_lo_q   <= '0;
      act_int_o <= '0;
      act_div_o <= '0;
      mod_o     <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_CFG: begin
          frac_en_o <= wr_data_i[0];
          wide_o    <= wr_data_i[1];
        end
        SEL_INT: begin
          st_int_q <= wr_data_i[P_INT_W-1:0];
          if (!frac_en_o) act_int_o <= wr_data_i[P_INT_W-1:0];
        end
        SEL_LO:  st_lo_q <= wr_data_i[P_LO_W-1:0];
        SEL_HI: begin
          if (frac_en_o) begin
            act_int_o <= st_int_q;
            act_div_o <= hi_div;
          end
        end
        SEL_MOD: mod_o <= wr_data_i[P_MOD_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fnr_offset_sat.sv
module fnr_offset_sat
  import fnr_pkg::*;
#(
  parameter int P_WIDE_W   = WIDE_W,
  parameter int P_NARROW_W = NARROW_W,
  parameter int P_MOD_W    = MOD_W
) (
  input  logic                       wide_i,
  input  logic signed [P_WIDE_W-1:0] act_div_i,
  input  logic signed [P_MOD_W-1:0]  mod_i,
  output logic [P_WIDE_W-1:0]        x_o,
  output logic                       neg_o
);
  localparam int SUM_W  = ((P_WIDE_W > P_MOD_W) ? P_WIDE_W : P_MOD_W) + 1;
  localparam int PAD_W  = P_WIDE_W - P_NARROW_W;
  localparam int WMAX_I = (1 << (P_WIDE_W - 1)) - 1;
  localparam int NMAX_I = (1 << (P_NARROW_W - 1)) - 1;

  logic signed [SUM_W-1:0] sum, lim_hi, lim_lo, sat;

  always_comb begin
    sum    = SUM_W'(act_div_i) + SUM_W'(mod_i);
    lim_hi = wide_i ? SUM_W'(WMAX_I) : SUM_W'(NMAX_I);
    lim_lo = wide_i ? SUM_W'(-WMAX_I - 1) : SUM_W'(-NMAX_I - 1);
    if (sum > lim_hi)      sat = lim_hi;
    else if (sum < lim_lo) sat = lim_lo;
    else                   sat = sum;
    neg_o = sat[SUM_W-1];
    // 10-bit values are scaled to the full accumulator range
    if (wide_i) x_o = sat[P_WIDE_W-1:0];
    else        x_o = {sat[P_NARROW_W-1:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/fnr_acc_stage.sv
module fnr_acc_stage #(
  parameter int ACC_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] in_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;

  assign {carry_o, sum_o} = {1'b0, acc_q} + {1'b0, in_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum_o;
  end
endmodule

// File: rtl/fnr_mash.sv
module fnr_mash
  import fnr_pkg::*;
#(
  parameter int ACC_W = WIDE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       tick_i,
  input  logic [ACC_W-1:0]           x_i,
  output logic signed [DITHER_W-1:0] y_o
);
  localparam int N_STAGE = 3;

  logic [ACC_W-1:0]   stage_in  [N_STAGE];
  logic [ACC_W-1:0]   stage_sum [N_STAGE];
  logic [N_STAGE-1:0] cy;
  logic c2_q, c3_q, c3_qq;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_in[s] = x_i;
    end else begin : g_next
      assign stage_in[s] = stage_sum[s-1];
    end
    fnr_acc_stage #(.ACC_W(ACC_W)) i_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (tick_i),
      .in_i   (stage_in[s]),
      .sum_o  (stage_sum[s]),
      .carry_o(cy[s])
    );
  end

  // noise cancellation: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else if (clr_i) begin
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else if (tick_i) begin
      c2_q  <= cy[1];
      c3_q  <= cy[2];
      c3_qq <= c3_q;
    end
  end

  always_comb begin
    y_o = DITHER_W'(cy[0]) + DITHER_W'(cy[1]) - DITHER_W'(c2_q)
        + DITHER_W'(cy[2]) - DITHER_W'({c3_q, 1'b0}) + DITHER_W'(c3_qq);
  end
endmodule

// File: rtl/fracn_ratio_seq.sv
module fracn_ratio_seq
  import fnr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               tick_i,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int CALC_W = RATIO_W + 2;

  logic                       frac_en, wide;
  logic [INT_W-1:0]           act_int;
  logic signed [WIDE_W-1:0]   act_div;
  logic signed [MOD_W-1:0]    mod_off;
  logic [WIDE_W-1:0]          mash_x;
  logic                       mash_neg;
  logic signed [DITHER_W-1:0] mash_y;
  logic [CALC_W-1:0]          base, next_ratio;

  fnr_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .frac_en_o(frac_en),
    .wide_o   (wide),
    .act_int_o(act_int),
    .act_div_o(act_div),
    .mod_o    (mod_off)
  );

  fnr_offset_sat i_sat (
    .wide_i   (wide),
    .act_div_i(act_div),
    .mod_i    (mod_off),
    .x_o      (mash_x),
    .neg_o    (mash_neg)
  );

  fnr_mash i_mash (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!frac_en),
    .tick_i(tick_i),
    .x_i   (mash_x),
    .y_o   (mash_y)
  );

  always_comb begin
    base = CALC_W'(act_int) + CALC_W'(RATIO_BIAS);
    if (frac_en) next_ratio = base - CALC_W'(mash_neg) + CALC_W'(mash_y);
    else         next_ratio = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ratio_o <= RATIO_W'(RATIO_BIAS);
    else if (tick_i) ratio_o <= next_ratio[RATIO_W-1:0];
  end
endmodule

// File: rtl/fnr_chk.sv
module fnr_chk
  import fnr_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       wr_en_i,
  input logic [SEL_W-1:0]           wr_sel_i,
  input logic                       frac_en_i,
  input logic [INT_W-1:0]           act_int_i,
  input logic signed [WIDE_W-1:0]   act_div_i,
  input logic signed [DITHER_W-1:0] y_i,
  input logic [RATIO_W-1:0]         ratio_o
);
  // R3
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ratio_o));

  // R2
  int_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frac_en_i) |=> (int'(ratio_o) == int'($past(act_int_i)) + RATIO_BIAS));

  // R8
  dither_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_en_i |-> (int'(y_i) >= -3 && int'(y_i) <= 4));

  // R8
  frac_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frac_en_i) |=>
      (int'(ratio_o) >= int'($past(act_int_i)) + RATIO_BIAS - 4 &&
       int'(ratio_o) <= int'($past(act_int_i)) + RATIO_BIAS + 4));

  // R7
  hi_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_HI && !frac_en_i) |=>
      ($stable(act_int_i) && $stable(act_div_i)));
endmodule

bind fracn_ratio_seq fnr_chk i_fnr_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .frac_en_i(frac_en),
  .act_int_i(act_int),
  .act_div_i(act_div),
  .y_i      (mash_y),
  .ratio_o  (ratio_o)
);

// File: tb/test_fracn_ratio_seq.sv
module test_fracn_ratio_seq;
  localparam int FULL  = 262144;
  localparam int WIN   = 4096;
  localparam real TOL  = 0.004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [9:0]  ratio;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  fracn_ratio_seq i_fracn_ratio_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tick_i(tick), .ratio_o(ratio)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // behavioural reference model
  int m_frac, m_wide, m_sti, m_stlo, m_ai, m_div, m_mod, m_ratio;
  int a1, a2, a3, c2q, c3q, c3qq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frac = 0; m_wide = 0; m_sti = 0; m_stlo = 0; m_ai = 0; m_div = 0;
      m_mod = 0; m_ratio = 32; a1 = 0; a2 = 0; a3 = 0; c2q = 0; c3q = 0; c3qq = 0;
    end else begin
      if (!m_frac) begin
        if (tick) m_ratio = m_ai + 32;
        a1 = 0; a2 = 0; a3 = 0; c2q = 0; c3q = 0; c3qq = 0;
      end else if (tick) begin
        int sum, lim, x, xu, neg, s, c1, c2, c3, y;
        sum = m_div + m_mod;
        lim = m_wide ? 131071 : 511;
        if (sum > lim) sum = lim;
        if (sum < -lim - 1) sum = -lim - 1;
        x = m_wide ? sum : sum * 256;
        neg = (x < 0) ? 1 : 0;
        xu = (x < 0) ? x + FULL : x;
        s = a1 + xu; c1 = (s >= FULL) ? 1 : 0; a1 = s - c1 * FULL;
        s = a2 + a1; c2 = (s >= FULL) ? 1 : 0; a2 = s - c2 * FULL;
        s = a3 + a2; c3 = (s >= FULL) ? 1 : 0; a3 = s - c3 * FULL;
        y = c1 + c2 - c2q + c3 - 2 * c3q + c3qq;
        c3qq = c3q; c3q = c3; c2q = c2;
        m_ratio = m_ai + 32 - neg + y;
      end
      if (wr_en) begin
        int d;
        d = int'(wr_data);
        case (wr_sel)
          3'd0: begin m_frac = d & 1; m_wide = (d >> 1) & 1; end
          3'd1: begin m_sti = d & 511; if (!m_frac) m_ai = d & 511; end
          3'd2: m_stlo = d & 255;
          3'd3: if (m_frac) begin
            m_ai = m_sti;
            if (m_wide) begin
              m_div = ((d & 1023) << 8) | m_stlo;
              if (m_div >= 131072) m_div -= FULL;
            end else begin
              m_div = ((d & 1023) ^ 512) - 512;
            end
          end
          3'd4: m_mod = ((d & 65535) ^ 32768) - 32768;
          default: ;
        endcase
      end
    end
  end

  // R8: every cycle against the model (dither sequence and range)
  always @(negedge clk) begin
    if (rst_n && cmp_on) check(int'(ratio) == m_ratio, "R8 per-cycle ratio", int'(ratio), m_ratio);
  end

  task automatic wr(int sel, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic mean_chk(string tag, real exp);
    real acc;
    real avg;
    acc = 0.0;
    tick = 1'b1;
    repeat (64) @(negedge clk);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      acc += real'(ratio);
    end
    tick = 1'b0;
    avg = acc / WIN;
    n_chk++;
    if (avg - exp > TOL || exp - avg > TOL) begin
      n_fail++;
      $display("FAIL %s actual=%f expected=%f", tag, avg, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ratio == 10'd32, "R1 reset ratio", int'(ratio), 32);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R3: no tick, no change; R2 after tick
    wr(1, 100);
    repeat (3) @(negedge clk);
    check(ratio == 10'd32, "R3 held without tick", int'(ratio), 32);
    pulse();
    check(ratio == 10'd132, "R2 integer ratio", int'(ratio), 132);
    wr(1, 511); pulse();
    check(ratio == 10'd543, "R2 integer max", int'(ratio), 543);
    wr(1, 0); pulse();
    check(ratio == 10'd32, "R2 integer min", int'(ratio), 32);

    // R10: unused select code has no effect
    wr(7, 123); pulse();
    check(ratio == 10'd32, "R10 unused select", int'(ratio), 32);

    // R7: upper dividend write ignored in integer mode
    wr(1, 200); pulse();
    wr(3, 5); wr(2, 3); pulse();
    check(ratio == 10'd232, "R7 upper write ignored", int'(ratio), 232);

    // 18-bit fractional; R6 staged writes do not commit
    wr(0, 3);
    wr(1, 13); wr(2, 'h98);
    mean_chk("R6 staged not committed", 232.0);
    check(ratio >= 10'd228 && ratio <= 10'd236, "R6 ratio window", int'(ratio), 232);
    wr(3, 'h07D);
    mean_chk("R4 positive dividend", 45.0 + 32152.0 / FULL);

    wr(1, 200); wr(2, 96); wr(3, 633);
    mean_chk("R4 negative dividend", 232.0 - 100000.0 / FULL);
    wr(1, 300); wr(2, 7);
    mean_chk("R6 staged in fractional", 232.0 - 100000.0 / FULL);

    // 10-bit fractional
    wr(0, 1);
    wr(1, 50); wr(3, 724);
    mean_chk("R5 negative 10-bit", 82.0 - 300.0 / 1024.0);
    wr(3, 200);
    mean_chk("R5 positive 10-bit", 82.0 + 200.0 / 1024.0);

    // R9 offset, plain and saturated
    wr(3, 500); wr(4, 100);
    mean_chk("R9 10-bit saturation", 82.0 + 511.0 / 1024.0);
    wr(4, 16'hFF38);
    mean_chk("R9 10-bit offset", 82.0 + 300.0 / 1024.0);
    wr(0, 3);
    wr(4, 16'hFC18);
    mean_chk("R9 18-bit offset", 82.0 - 500.0 / FULL);
    wr(2, 'hFF); wr(3, 'h1FF); wr(4, 1000);
    mean_chk("R9 18-bit saturation", 82.0 + 131071.0 / FULL);

    // back to integer mode
    wr(0, 0); wr(1, 77); pulse();
    check(ratio == 10'd109, "R2 integer after fractional", int'(ratio), 109);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule